// File: doc/BRIEF.md
# Kernel Tick and Timer Bank

This block is the hardware time base for a small real-time kernel. A programmable prescaler divides the system clock into a periodic tick. Each tick does three things. It advances a free-running system time counter. It steps a bank of general-purpose kernel timers. It raises a one-cycle tick interrupt to the processor. All kernel time parameters are therefore whole multiples of the tick.

Each kernel timer has its own enable, its own count direction and a loadable count.

- A timer counting down stops at zero and flags expiry there.
- A timer counting up flags expiry when its count reaches a programmable compare value.

When the system time counter runs past its range, it wraps to zero and raises a sticky timing-error flag. The host programs everything through a simple write port and reads state back through a combinational read port. Expiry flags and the error flag are cleared by writing ones to the status word.

Top module: `ktb_timebase`

## Requirements
- R1: After reset, every count, compare value, flag, the divider and the system time read as zero, and `tick_irq` is low.
- R2: With divider value N > 0 (register address 0x00), `tick_irq` pulses high for one clock once every N clocks. N = 0 produces no ticks. Writing the divider restarts the period, so the first tick comes N clocks after the write.
- R3: The system time (address 0x01, read only) increases by exactly one on every tick and is otherwise stable.
- R4: A tick that arrives while the system time is all ones sets it to zero and sets `time_err`.
- R5: An enabled timer with direction bit 0 decrements on each tick. When the tick leaves its count at zero, its expiry flag is set. A count of zero stays at zero on further ticks.
- R6: An enabled timer with direction bit 1 increments on each tick, wrapping at its width. Its expiry flag is set on the tick that makes the count equal its compare value.
- R7: A disabled timer keeps its count and sets no flag on ticks.
- R8: The status word (address 0x02) holds `time_err` in bit 0 and the expiry flag of timer i in bit i+1. The flags are sticky. Writing 1 to a bit clears it, and a set in the same cycle wins over the clear.
- R9: A host write to a timer count in the same cycle as a tick loads the written value, and that tick neither steps the count nor sets the timer's flag.
- R10: Timer i occupies addresses 0x10+4i (control: bit 0 enable, bit 1 direction), 0x11+4i (count) and 0x12+4i (compare). All of these read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Combinational read data |
| tick_irq | output | 1 | One-cycle tick interrupt |
| time_err | output | 1 | Sticky system time overflow flag |
| expired | output | NUM_TMR | Sticky expiry flag per timer |

## Verification
The bench builds the block with an 8-bit system time, 8-bit timer counts and an 8-bit divider, keeping four timers. Narrowing the system time to 8 bits lets a divider of 1 wrap it within a few hundred clocks, so the overflow path is exercised under both directed and random traffic. The same narrowing applies to the counts: up-counters wrap and pass their compare values often, and down-counters park at zero within a short run. Small random divider values keep ticks dense, so host writes frequently land in the same cycle as a tick.

// File: rtl/ktb_pkg.sv
package ktb_pkg;
  localparam int ADR_DIV        = 0;
  localparam int ADR_TIME       = 1;
  localparam int ADR_STAT       = 2;
  localparam int ADR_TMR_BASE   = 16;
  localparam int ADR_TMR_STRIDE = 4;

  typedef enum logic [1:0] {
    TR_CTRL  = 2'd0,
    TR_COUNT = 2'd1,
    TR_CMP   = 2'd2
  } tmr_reg_e;
endpackage

// File: rtl/ktb_tick_gen.sv
module ktb_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  output logic [DIV_W-1:0] div_q,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] pcnt_q, pcnt_d, div_d;

  always_comb begin
    tick  = (div_q != '0) && (pcnt_q == div_q - ONE);
    div_d = div_we ? div_wdata : div_q;
    if (div_we || (div_q == '0) || tick) pcnt_d = '0;
    else                                 pcnt_d = pcnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      pcnt_q <= '0;
    end else begin
      div_q  <= div_d;
      pcnt_q <= pcnt_d;
    end
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_q > ONE && !div_we) |=> !tick);
endmodule

// File: rtl/ktb_sys_time.sv
module ktb_sys_time #(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              err_clr,
  output logic [TIME_W-1:0] time_q,
  output logic              err_q
);
  logic [TIME_W-1:0] time_d;
  logic              err_d;
  logic              at_max;

  always_comb begin
    at_max = &time_q;
    time_d = time_q;
    err_d  = err_q && !err_clr;
    if (tick) begin
      if (at_max) begin
        time_d = '0;
        err_d  = 1'b1;
      end else begin
        time_d = time_q + TIME_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
      err_q  <= 1'b0;
    end else begin
      time_q <= time_d;
      err_q  <= err_d;
    end
  end

  // R3
  time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !at_max) |=> (time_q == $past(time_q) + TIME_W'(1)));
  // R4
  time_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_max) |=> (time_q == '0 && err_q));
endmodule

// File: rtl/ktb_timer.sv
module ktb_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ctrl_we,
  input  logic [1:0]       ctrl_wdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             flag_clr,
  output logic             en_q,
  output logic             up_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic             flag_q
);
  logic [CNT_W-1:0] cnt_d, cmp_d, step_val;
  logic             en_d, up_d, flag_d, hit, advance;

  always_comb begin
    if (up_q)               step_val = cnt_q + CNT_W'(1);
    else if (cnt_q == '0)   step_val = '0;
    else                    step_val = cnt_q - CNT_W'(1);
    hit     = up_q ? (step_val == cmp_q) : (step_val == '0);
    advance = tick && en_q;
    en_d    = ctrl_we ? ctrl_wdata[0] : en_q;
    up_d    = ctrl_we ? ctrl_wdata[1] : up_q;
    cmp_d   = cmp_we  ? cmp_wdata     : cmp_q;
    if (cnt_we)       cnt_d = cnt_wdata;
    else if (advance) cnt_d = step_val;
    else              cnt_d = cnt_q;
    flag_d  = (flag_q && !flag_clr) || (advance && !cnt_we && hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      up_q   <= 1'b0;
      cnt_q  <= '0;
      cmp_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      up_q   <= up_d;
      cnt_q  <= cnt_d;
      cmp_q  <= cmp_d;
      flag_q <= flag_d;
    end
  end

  // R5
  down_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en_q && !up_q && cnt_q == '0 && !cnt_we) |=> (cnt_q == '0 && flag_q));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !cnt_we) |=> $stable(cnt_q));
  // R9
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_q == $past(cnt_wdata)));
endmodule

// File: rtl/ktb_timebase.sv
module ktb_timebase #(
  parameter int NUM_TMR = 4,
  parameter int TIME_W  = 32,
  parameter int CNT_W   = 32,
  parameter int DIV_W   = 16,
  parameter int ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [31:0]        wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [31:0]        rd_data,
  output logic               tick_irq,
  output logic               time_err,
  output logic [NUM_TMR-1:0] expired
);
  import ktb_pkg::*;

  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(ADR_DIV);
  localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(ADR_TIME);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);

  function automatic logic [ADDR_W-1:0] tmr_addr(input int idx, input tmr_reg_e r);
    return ADDR_W'(ADR_TMR_BASE + idx * ADR_TMR_STRIDE + int'(r));
  endfunction

  logic               tick, irq_d;
  logic [DIV_W-1:0]   div_q;
  logic [TIME_W-1:0]  time_q;
  logic               stat_we;
  logic [NUM_TMR-1:0] en_v, up_v;
  logic [CNT_W-1:0]   cnt_v [NUM_TMR];
  logic [CNT_W-1:0]   cmp_v [NUM_TMR];

  assign stat_we = wr_en && (wr_addr == A_STAT);
  assign irq_d   = tick;

  ktb_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk, .rst_n,
    .div_we   (wr_en && (wr_addr == A_DIV)),
    .div_wdata(wr_data[DIV_W-1:0]),
    .div_q    (div_q),
    .tick     (tick)
  );

  ktb_sys_time #(.TIME_W(TIME_W)) u_time (
    .clk, .rst_n,
    .tick   (tick),
    .err_clr(stat_we && wr_data[0]),
    .time_q (time_q),
    .err_q  (time_err)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    ktb_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk, .rst_n,
      .tick      (tick),
      .ctrl_we   (wr_en && (wr_addr == tmr_addr(g, TR_CTRL))),
      .ctrl_wdata(wr_data[1:0]),
      .cnt_we    (wr_en && (wr_addr == tmr_addr(g, TR_COUNT))),
      .cnt_wdata (wr_data[CNT_W-1:0]),
      .cmp_we    (wr_en && (wr_addr == tmr_addr(g, TR_CMP))),
      .cmp_wdata (wr_data[CNT_W-1:0]),
      .flag_clr  (stat_we && wr_data[g+1]),
      .en_q      (en_v[g]),
      .up_q      (up_v[g]),
      .cnt_q     (cnt_v[g]),
      .cmp_q     (cmp_v[g]),
      .flag_q    (expired[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_irq <= 1'b0;
    else        tick_irq <= irq_d;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_DIV)  rd_data = DATA_W'(div_q);
    if (rd_addr == A_TIME) rd_data = DATA_W'(time_q);
    if (rd_addr == A_STAT) rd_data = DATA_W'({expired, time_err});
    for (int i = 0; i < NUM_TMR; i++) begin
      if (rd_addr == tmr_addr(i, TR_CTRL))  rd_data = DATA_W'({up_v[i], en_v[i]});
      if (rd_addr == tmr_addr(i, TR_COUNT)) rd_data = DATA_W'(cnt_v[i]);
      if (rd_addr == tmr_addr(i, TR_CMP))   rd_data = DATA_W'(cmp_v[i]);
    end
  end

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (time_err && !(stat_we && wr_data[0])) |=> time_err);
  // R2
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0 && !(wr_en && wr_addr == A_DIV)) |=> !tick_irq);
endmodule

// File: tb/tb_ktb_timebase.sv
`timescale 1ns/100ps
module tb_ktb_timebase;
  localparam int NT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        tick_irq, time_err;
  logic [NT-1:0] expired;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  ktb_timebase #(.NUM_TMR(NT), .TIME_W(8), .CNT_W(8), .DIV_W(8), .ADDR_W(6)) dut (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .tick_irq, .time_err, .expired
  );

  // reference state
  logic [7:0] m_div, m_pcnt, m_time;
  logic       m_err, m_irq;
  logic [7:0] m_cnt [NT];
  logic [7:0] m_cmp [NT];
  logic       m_en [NT];
  logic       m_up [NT];
  logic       m_flag [NT];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] stat_exp();
    logic [31:0] s = {31'd0, m_err};
    for (int i = 0; i < NT; i++) s[i+1] = m_flag[i];
    return s;
  endfunction

  task automatic model_reset();
    m_div = 0; m_pcnt = 0; m_time = 0; m_err = 0; m_irq = 0;
    for (int i = 0; i < NT; i++) begin
      m_cnt[i] = 0; m_cmp[i] = 0; m_en[i] = 0; m_up[i] = 0; m_flag[i] = 0;
    end
  endtask

  task automatic model_step(input logic we, input logic [5:0] wa, input logic [31:0] wd);
    logic tk;
    logic [7:0] nc;
    logic hit;
    tk = (m_div != 0) && (m_pcnt == m_div - 8'd1);
    m_irq = tk;
    if (we && wa == 6'd0) begin m_div = wd[7:0]; m_pcnt = 0; end
    else if (m_div == 0 || tk) m_pcnt = 0;
    else m_pcnt = m_pcnt + 8'd1;
    if (we && wa == 6'd2 && wd[0]) m_err = 0;
    if (tk) begin
      if (m_time == 8'hFF) begin m_time = 0; m_err = 1; end
      else m_time = m_time + 8'd1;
    end
    for (int i = 0; i < NT; i++) begin
      logic cw;
      cw = we && (wa == 6'(16 + 4*i + 1));
      if (we && wa == 6'd2 && wd[i+1]) m_flag[i] = 0;
      if (tk && m_en[i]) begin
        if (m_up[i]) begin nc = m_cnt[i] + 8'd1; hit = (nc == m_cmp[i]); end
        else begin nc = (m_cnt[i] == 0) ? 8'd0 : m_cnt[i] - 8'd1; hit = (nc == 0); end
        if (!cw) begin m_cnt[i] = nc; if (hit) m_flag[i] = 1; end
      end
      if (cw) m_cnt[i] = wd[7:0];
      if (we && wa == 6'(16 + 4*i)) begin m_en[i] = wd[0]; m_up[i] = wd[1]; end
      if (we && wa == 6'(16 + 4*i + 2)) m_cmp[i] = wd[7:0];
    end
  endtask

  task automatic check_all();
    chk("R2 tick_irq", 32'(tick_irq), 32'(m_irq));
    chk("R4 time_err", 32'(time_err), 32'(m_err));
    rd_addr = 6'd1; #0.5;
    chk("R3 system time", rd_data, 32'(m_time));
    rd_addr = 6'd2; #0.5;
    chk("R8 status", rd_data, stat_exp());
    for (int i = 0; i < NT; i++) begin
      rd_addr = 6'(16 + 4*i + 1); #0.5;
      chk(m_up[i] ? "R6 up count" : "R5 down count", rd_data, 32'(m_cnt[i]));
    end
  endtask

  task automatic step(input logic we, input logic [5:0] wa, input logic [31:0] wd);
    wr_en = we; wr_addr = wa; wr_data = wd;
    model_step(we, wa, wd);
    @(posedge clk); #1;
    wr_en = 1'b0;
    check_all();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 6'd0, 32'd0);
  endtask

  function automatic logic [5:0] rand_addr();
    int r = int'($urandom % 5);
    int t = int'($urandom % NT);
    case (r)
      0: return 6'd0;
      1: return 6'd2;
      2: return 6'(16 + 4*t);
      3: return 6'(16 + 4*t + 1);
      default: return 6'(16 + 4*t + 2);
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int irqs;
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    for (int a = 0; a < 32; a++) begin
      rd_addr = 6'(a); #0.2;
      chk("R1 reset readback", rd_data, 32'd0);
    end
    chk("R1 reset irq", 32'(tick_irq), 32'd0);
    @(negedge clk);
    // R2: zero divider gives no ticks
    irqs = 0;
    for (int k = 0; k < 20; k++) begin step(1'b0, 6'd0, 0); irqs += int'(tick_irq); end
    chk("R2 no tick with zero divider", 32'(irqs), 32'd0);
    // R2: divider 3 -> one tick per 3 clocks
    step(1'b1, 6'd0, 32'd3);
    irqs = 0;
    for (int k = 0; k < 30; k++) begin step(1'b0, 6'd0, 0); irqs += int'(tick_irq); end
    chk("R2 tick count divider 3", 32'(irqs), 32'd10);
    // R4: overflow with divider 1
    step(1'b1, 6'd0, 32'd1);
    idle(260);
    chk("R4 overflow sets error", 32'(time_err), 32'd1);
    // R8: clear error by writing 1
    step(1'b1, 6'd2, 32'd1);
    chk("R8 error cleared", 32'(time_err), 32'd0);
    // R5: timer 0 down from 3
    step(1'b1, 6'd17, 32'd3);
    step(1'b1, 6'd16, 32'd1);
    idle(6);
    rd_addr = 6'd17; #0.5;
    chk("R5 down timer parks at zero", rd_data, 32'd0);
    chk("R5 down timer flag", 32'(expired[0]), 32'd1);
    // R7: timer 1 disabled holds
    step(1'b1, 6'd21, 32'h55);
    idle(5);
    rd_addr = 6'd21; #0.5;
    chk("R7 disabled timer holds", rd_data, 32'h55);
    chk("R7 disabled timer no flag", 32'(expired[1]), 32'd0);
    // R6: timer 2 up with compare 5
    step(1'b1, 6'd26, 32'd5);
    step(1'b1, 6'd24, 32'd3);
    idle(6);
    chk("R6 up timer flag at compare", 32'(expired[2]), 32'd1);
    // R9: count write in a tick cycle (divider 1 ticks every clock)
    step(1'b1, 6'd25, 32'h40);
    rd_addr = 6'd25; #0.5;
    chk("R9 write beats tick", rd_data, 32'h40);
    // R10: control and compare readback
    step(1'b1, 6'd28, 32'd2);
    rd_addr = 6'd28; #0.5;
    chk("R10 ctrl readback", rd_data, 32'd2);
    rd_addr = 6'd26; #0.5;
    chk("R10 compare readback", rd_data, 32'd5);
    rd_addr = 6'd0; #0.5;
    chk("R10 divider readback", rd_data, 32'd1);
    // R8: clear all flags
    step(1'b1, 6'd2, 32'h1F);
    // random traffic
    for (int k = 0; k < 3000; k++) begin
      if (($urandom % 100) < 10) begin
        logic [5:0] a;
        logic [31:0] d;
        a = rand_addr();
        d = $urandom;
        if (a == 6'd0) d = $urandom % 5;
        else if (($urandom % 2) == 0) d = $urandom % 8;
        step(1'b1, a, d);
      end else begin
        step(1'b0, 6'd0, 0);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule